// File: doc/BRIEF.md
# Dual-Mode Cartridge Bank Translator

This block turns CPU register writes into bank state and uses that state to build the wide ROM addresses a cartridge needs. The CPU drives a write strobe, an address and a data byte. Two index registers, one data register and two outer-bank registers sit at fixed decoded addresses. The block then maps the CPU window $8000-$FFFF onto PRG-ROM in 8 KiB slots. It also maps the PPU pattern window $0000-$1FFF onto CHR-ROM in 1 KiB slots.

The mode bit is taken from the index byte written last. In compatible mode the block follows the familiar eight-register scheme. Two PRG registers and six CHR registers are used, with a PRG swap bit and a CHR half-swap bit. The top PRG slot is pinned to the last bank. In extended mode all four PRG slots are free, and their bank data arrives bit-reversed. Each 1 KiB CHR slot then gets a bank number that is an OR of three parts: the shifted data byte, a separately latched high field and, in some slots, a forced low bit. A two-bit outer bank places everything inside one of four 128 KiB regions.

Top module: `cart_bank_xlate`

## Requirements
- R1: A write is taken only when `cpu_wr` is high at a rising clock edge. Under mask $E003, an address equal to $8000 or $8002 is an index write and $8001 is a data write. Under mask $5003, $5002 is outer-bit-0 and $5003 is outer-bit-1. Writes to any other address change nothing.
- R2: After reset the outer bank is 3, the index byte is 0 (compatible mode, no swaps), and PRG gives banks 0,1,14,15 for $8000,$A000,$C000,$E000. Compatible CHR registers are 0. Extended CHR slots 1 and 3 hold bank 1 and all other extended state is 0.
- R3: The index byte written last, through either index address, supplies the target number (bits 4..0) for the next data write. It also supplies the mode (bit 5: 0 compatible, 1 extended), the PRG swap (bit 6) and the CHR swap (bit 7).
- R4: Compatible PRG: a data write with target n (bits 2..0) stores the byte in register n. Without the PRG swap, slots $8000,$A000,$C000,$E000 use reg6, reg7, 14, 15. With the swap they use 14, reg7, reg6, 15. Only the low 4 bits of a register are used.
- R5: Compatible CHR: with PPU A12 XOR the CHR swap equal to 0, PPU A11 picks reg0 or reg1. The bank is then that register with bit 0 replaced by PPU A10. Otherwise slot A11..A10 uses reg 2+slot. Only the low 7 bits are used.
- R6: Extended PRG: targets $06,$05,$04,$03 (index $26..$23) load the slot at $8000,$A000,$C000,$E000. Bank bit 0..3 are data bits 5,4,3,2.
- R7: Extended CHR latch: an even target from $08 to $1E stores data bits 2..0. The stored value shifted left by 4 is ORed into every later extended CHR bank write.
- R8: Extended lower table: an odd target $09-$0F writes slot index bits 2..1 ($0000,$0400,$0800,$0C00) with (data>>1) | (latch<<4) | index bit 1. The $0400 and $0C00 slots therefore always get bank bit 0 set.
- R9: Extended upper table: an odd target $11-$1F writes slot 4 + index bits 3..2 with (data>>1) | (latch<<4).
- R10: Outer bank bit 0 comes from data bit 0 at $5002 and bit 1 from data bit 5 at $5003. It forms address bits 18..17 of both outputs in both modes.
- R11: `prg_addr` = {outer, 4-bit bank, cpu_addr[12:0]} and `chr_addr` = {outer, 7-bit bank, ppu_addr[9:0]}. Both follow the address inputs combinationally.
- R12: With `cpu_wr` low, no value on the address and data inputs alters any output for a given address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address, used for writes and for PRG translation |
| cpu_din | input | 8 | CPU write data |
| ppu_addr | input | 13 | PPU pattern address |
| prg_addr | output | 19 | Translated PRG-ROM address |
| chr_addr | output | 19 | Translated CHR-ROM address |

## Verification
Every register drives an output bit directly, so a bad stored value shows up as a wrong bank field. It appears on the first lookup of the slot that register feeds, one cycle after the write. The wrong state can be hidden until the right slot is read, and the slot in use depends on the mode. Examples are a reversal or latch OR that went wrong, or a missed forced low bit. For that reason the bench sweeps all four PRG slots and all eight CHR slots after every write. A stale index or a lost mode bit instead misroutes a later data write, which then shows on a slot that should not have moved.

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate #(
  parameter int OUT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_din,
  input  logic [12:0]       ppu_addr,
  output logic [OUT_W+16:0] prg_addr,
  output logic [OUT_W+16:0] chr_addr
);
  localparam int PB = 4;
  localparam int CB = 7;

  logic [7:0]       idx;
  logic [OUT_W-1:0] outer;
  logic [7:0]       creg [8];
  logic [PB-1:0]    xprg [4];
  logic [CB-1:0]    xchr [8];
  logic [2:0]       lat;

  wire sel_hit = cpu_wr && ((cpu_addr & 16'hE003) == 16'h8000 || (cpu_addr & 16'hE003) == 16'h8002);
  wire dat_hit = cpu_wr && (cpu_addr & 16'hE003) == 16'h8001;
  wire o0_hit  = cpu_wr && (cpu_addr & 16'h5003) == 16'h5002;
  wire o1_hit  = cpu_wr && (cpu_addr & 16'h5003) == 16'h5003;

  wire [4:0] tgt   = idx[4:0];
  wire       ext   = idx[5];
  wire       x_prg = tgt >= 5'd3 && tgt <= 5'd6;
  wire       x_lat = tgt >= 5'd8 && !tgt[0];
  wire       x_lo  = tgt[4:3] == 2'b01 && tgt[0];
  wire       x_hi  = tgt[4] && tgt[0];
  wire [2:0] pslot = 3'd6 - tgt[2:0];
  wire [CB-1:0] base = cpu_din[7:1] | {lat, 4'b0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      outer <= '1;
      lat   <= '0;
      for (int i = 0; i < 8; i++) begin
        creg[i] <= (i == 7) ? 8'd1 : 8'd0;
        xchr[i] <= (i == 1 || i == 3) ? CB'(1) : '0;
      end
      xprg[0] <= 4'd0;
      xprg[1] <= 4'd1;
      xprg[2] <= 4'd14;
      xprg[3] <= 4'd15;
    end else begin
      if (sel_hit) idx <= cpu_din;
      if (o0_hit) outer[0] <= cpu_din[0];
      if (o1_hit) outer[1] <= cpu_din[5];
      if (dat_hit) begin
        if (!ext) creg[tgt[2:0]] <= cpu_din;
        else if (x_prg) xprg[pslot[1:0]] <= {cpu_din[2], cpu_din[3], cpu_din[4], cpu_din[5]};
        else if (x_lat) lat <= cpu_din[2:0];
        else if (x_lo) xchr[{1'b0, tgt[2:1]}] <= base | {6'b0, tgt[1]};
        else if (x_hi) xchr[{1'b1, tgt[3:2]}] <= base;
      end
    end
  end

  logic [PB-1:0] c_pbank;
  logic [CB-1:0] c_cbank;
  wire  [1:0]    ps  = cpu_addr[14:13];
  wire           a12 = ppu_addr[12] ^ idx[7];
  wire  [2:0]    hi_reg = {1'b0, ppu_addr[11:10]} + 3'd2;

  always_comb begin
    case (ps)
      2'd0:    c_pbank = idx[6] ? 4'd14 : creg[6][PB-1:0];
      2'd1:    c_pbank = creg[7][PB-1:0];
      2'd2:    c_pbank = idx[6] ? creg[6][PB-1:0] : 4'd14;
      default: c_pbank = 4'd15;
    endcase
    if (!a12) c_cbank = {creg[{2'b00, ppu_addr[11]}][CB-1:1], ppu_addr[10]};
    else      c_cbank = creg[hi_reg][CB-1:0];
  end

  wire [PB-1:0] pbank = ext ? xprg[ps] : c_pbank;
  wire [CB-1:0] cbank = ext ? xchr[ppu_addr[12:10]] : c_cbank;

  assign prg_addr = {outer, pbank, cpu_addr[12:0]};
  assign chr_addr = {outer, cbank, ppu_addr[9:0]};

  assert_outer_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    o0_hit |=> prg_addr[17] == $past(cpu_din[0]));
  assert_outer_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    o1_hit |=> chr_addr[18] == $past(cpu_din[5]));
  assert_top_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext && ps == 2'd3) |-> prg_addr[16:13] == 4'hF);
  assert_odd_lsb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext && !ppu_addr[12] && ppu_addr[10]) |-> chr_addr[10]);
  assert_offset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prg_addr[12:0] == cpu_addr[12:0] && chr_addr[9:0] == ppu_addr[9:0]);
  assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cpu_wr) && $stable(cpu_addr) && $stable(ppu_addr)) |-> ($stable(prg_addr) && $stable(chr_addr)));
endmodule

// File: tb/test_cart_bank_xlate.sv
module test_cart_bank_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_wr = 0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [7:0]  cpu_din = 0;
  logic [12:0] ppu_addr = 0;
  logic [18:0] prg_addr, chr_addr;

  int checks = 0, errors = 0;

  cart_bank_xlate i_cart_bank_xlate (.clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_din(cpu_din), .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr));

  always #5 clk = ~clk;

  logic [7:0] m_idx;
  logic [1:0] m_out;
  logic [7:0] m_r [8];
  logic [3:0] m_p [4];
  logic [6:0] m_c [8];
  logic [2:0] m_lat;

  task automatic m_reset();
    m_idx = 0; m_out = 3; m_lat = 0;
    for (int i = 0; i < 8; i++) begin
      m_r[i] = (i == 7) ? 8'd1 : 8'd0;
      m_c[i] = (i == 1 || i == 3) ? 7'd1 : 7'd0;
    end
    m_p[0] = 0; m_p[1] = 1; m_p[2] = 14; m_p[3] = 15;
  endtask

  task automatic m_write(input logic [15:0] a, input logic [7:0] d);
    logic [4:0] t;
    logic [6:0] b;
    t = m_idx[4:0];
    b = {1'b0, d[7:1]} | {m_lat, 4'b0};
    if ((a & 16'h5003) == 16'h5002) m_out[0] = d[0];
    if ((a & 16'h5003) == 16'h5003) m_out[1] = d[5];
    if ((a & 16'hE003) == 16'h8001) begin
      if (!m_idx[5]) m_r[t[2:0]] = d;
      else if (t == 6) m_p[0] = {d[2], d[3], d[4], d[5]};
      else if (t == 5) m_p[1] = {d[2], d[3], d[4], d[5]};
      else if (t == 4) m_p[2] = {d[2], d[3], d[4], d[5]};
      else if (t == 3) m_p[3] = {d[2], d[3], d[4], d[5]};
      else if (t >= 8 && t[0] == 0) m_lat = d[2:0];
      else if (t >= 9 && t <= 15 && t[0]) m_c[t[2:1]] = b | {6'b0, t[1]};
      else if (t >= 17 && t[0]) m_c[4 + t[3:2]] = b;
    end
    if ((a & 16'hE003) == 16'h8000 || (a & 16'hE003) == 16'h8002) m_idx = d;
  endtask

  function automatic logic [18:0] exp_prg(input logic [15:0] a);
    logic [3:0] bk;
    if (m_idx[5]) bk = m_p[a[14:13]];
    else case (a[14:13])
      2'd0: bk = m_idx[6] ? 4'd14 : m_r[6][3:0];
      2'd1: bk = m_r[7][3:0];
      2'd2: bk = m_idx[6] ? m_r[6][3:0] : 4'd14;
      default: bk = 4'd15;
    endcase
    return {m_out, bk, a[12:0]};
  endfunction

  function automatic logic [18:0] exp_chr(input logic [12:0] p);
    logic [6:0] bk;
    logic       h;
    h = p[12] ^ m_idx[7];
    if (m_idx[5]) bk = m_c[p[12:10]];
    else if (!h) bk = {m_r[p[11] ? 1 : 0][6:1], p[10]};
    else bk = m_r[2 + p[11:10]][6:0];
    return {m_out, bk, p[9:0]};
  endfunction

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic we);
    @(negedge clk);
    cpu_addr = a; cpu_din = d; cpu_wr = we;
    @(negedge clk);
    cpu_wr = 0;
    if (we) m_write(a, d);
  endtask

  task automatic chk_prg(input string tag, input logic [15:0] a);
    cpu_addr = a; #1;
    checks++;
    if (prg_addr !== exp_prg(a)) begin
      errors++;
      $display("FAIL %s prg at %h: got %h expected %h", tag, a, prg_addr, exp_prg(a));
    end
  endtask

  task automatic chk_chr(input string tag, input logic [12:0] p);
    ppu_addr = p; #1;
    checks++;
    if (chr_addr !== exp_chr(p)) begin
      errors++;
      $display("FAIL %s chr at %h: got %h expected %h", tag, p, chr_addr, exp_chr(p));
    end
  endtask

  task automatic sweep(input string tp, input string tc);
    for (int s = 0; s < 4; s++) chk_prg(tp, 16'h8000 + 16'(s * 16'h2000) + 16'($urandom_range(0, 8191)));
    for (int s = 0; s < 8; s++) chk_chr(tc, 13'(s * 1024) + 13'($urandom_range(0, 1023)));
  endtask

  task automatic chk_val(input string tag, input logic [18:0] got, input logic [18:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    cpu_addr = 16'h8000; #1; chk_val("R2", prg_addr, {2'b11, 4'd0, 13'd0});
    cpu_addr = 16'hA000; #1; chk_val("R2", prg_addr, {2'b11, 4'd1, 13'd0});
    cpu_addr = 16'hC000; #1; chk_val("R2", prg_addr, {2'b11, 4'd14, 13'd0});
    cpu_addr = 16'hE000; #1; chk_val("R2", prg_addr, {2'b11, 4'd15, 13'd0});
    sweep("R2", "R2");
    // R6 reversed PRG bits
    bus(16'h8002, 8'h26, 1);
    bus(16'h8001, 8'h20, 1);
    cpu_addr = 16'h8123; #1; chk_val("R6", prg_addr, {2'b11, 4'd1, 13'h0123});
    bus(16'h8000, 8'h23, 1);
    bus(16'h8001, 8'h04, 1);
    cpu_addr = 16'hE000; #1; chk_val("R6", prg_addr, {2'b11, 4'd8, 13'd0});
    // R7 R8 latch OR and forced LSB
    bus(16'h8002, 8'h28, 1);
    bus(16'h8001, 8'h05, 1);
    bus(16'h8002, 8'h2B, 1);
    bus(16'h8001, 8'h00, 1);
    ppu_addr = 13'h0400; #1; chk_val("R8", chr_addr, {2'b11, 7'h51, 10'd0});
    // R9 upper table
    bus(16'h8002, 8'h3D, 1);
    bus(16'h8001, 8'h0E, 1);
    ppu_addr = 13'h1C05; #1; chk_val("R9", chr_addr, {2'b11, 7'h57, 10'h005});
    // R3 index via the other address keeps extended mode, retargets
    bus(16'h8000, 8'h35, 1);
    bus(16'h8001, 8'h02, 1);
    ppu_addr = 13'h1400; #1; chk_val("R3", chr_addr, {2'b11, 7'h51, 10'd0});
    // R10 outer bits
    bus(16'h5002, 8'hFE, 1);
    bus(16'h5003, 8'hDF, 1);
    cpu_addr = 16'h8000; #1; chk_val("R10", prg_addr, {2'b00, 4'd1, 13'd0});
    // R1 mirror decode and ignored address
    bus(16'h9FFE, 8'h06, 1);
    bus(16'hA001, 8'h26, 1);
    bus(16'h9FFD, 8'h09, 1);
    cpu_addr = 16'h8000; #1; chk_val("R1", prg_addr, {2'b00, 4'd9, 13'd0});
    // R12 strobe low
    bus(16'h8001, 8'hFF, 0);
    bus(16'h5002, 8'hFF, 0);
    sweep("R12", "R12");
    // R4 R5 swap bits
    bus(16'h8000, 8'hC0, 1);
    bus(16'h8001, 8'h7A, 1);
    sweep("R4", "R5");
    // R11 random offsets
    for (int k = 0; k < 4; k++) begin
      logic [15:0] a;
      a = 16'h8000 | 16'($urandom_range(0, 32767));
      chk_prg("R11", a);
    end
    // random phase
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int          c;
      c = $urandom_range(0, 9);
      d = 8'($urandom);
      if (c < 3) a = 16'h8000 | (16'($urandom) & 16'h1FFC) | (c == 0 ? 16'h0002 : 16'h0000);
      else if (c < 7) a = 16'h8001 | (16'($urandom) & 16'h1FFC);
      else if (c == 7) a = 16'h5002 | (16'($urandom) & 16'hAFFC) | 16'($urandom_range(0, 1));
      else a = 16'($urandom);
      if (c < 3 && $urandom_range(0, 1) == 1) d[5] = 1;
      bus(a, d, $urandom_range(0, 7) != 0);
      sweep(m_idx[5] ? "R6" : "R4", m_idx[5] ? "R8 R9" : "R5");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule